// File: doc/BRIEF.md
# Double-Buffered Audio DMA Pointer Controller

This block sits between an audio serial framing engine and on-chip memory. Each time the framing engine finishes a word slot it pulses a tick. The controller then stores the captured receive word at the current receive address and fetches the next transmit word from the current transmit address. Transmit and receive each have their own buffer pointer register, but a single word-count register sets the buffer length for both directions. The count is in 32-bit words, and every buffer starts on a 4-byte boundary.

Software arms the controller by writing both pointers, the count and the direction enables, and then issuing the start task. The pointers are copied into working bases at start and again at every buffer boundary. A pointer-updated event then tells software that the register is free for the next buffer's address. If software writes nothing new, the controller reuses the old pointer, so streaming continues without a gap. A stop task ends all traffic and raises a stopped event. Events are cleared by writing zero to them, and each event reaches the interrupt line only when its enable bit is set. The set and clear registers for the enables are separate.

Top module: `audio_dma_ptr`

## Requirements
- R1: After reset all three events, `irq`, `cntErr`, `memReq`, `memWe` and `txWord` are 0.
- R2: Register writes use `regAddr` word indices: 0 start task, 1 stop task, 2 enables (bit0 transmit, bit1 receive), 3 transmit pointer, 4 receive pointer, 5 word count, 6/7/8 transmit/receive/stopped event, 9 interrupt-enable set, 10 interrupt-enable clear. Bits [1:0] of a written pointer are forced to zero. Word k of a buffer is at byte address base + 4k.
- R3: A start task issued while idle copies both pointers and the count into the working state, resets the word index, and raises the pointer-updated event of every enabled direction in the next cycle. A start task issued while running has no effect.
- R4: A tick sampled while running and idle is served as follows. In the next cycle a receive write request carries the `rxWord` sampled with the tick. In the cycle after that a transmit read request is issued, and the `memRdata` of that cycle appears on `txWord` in the following cycle. Ticks that arrive while this sequence is in progress are ignored.
- R5: When the read cycle of the last word of a buffer ends, both bases and the count reload from their registers (old values if they were not rewritten), the index returns to 0, and each active direction raises its pointer-updated event. The next tick continues at the new base.
- R6: Clearing a direction's enable while running stops that direction's memory requests and raises its pointer-updated event in the next cycle. Setting an enable while running has no effect until the next start.
- R7: A stop task raises the stopped event in the next cycle, and no memory request is issued after it until a new start.
- R8: Writing zero to an event's index clears that event, and a non-zero write leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R9: Interrupt-enable bits are bit0 transmit, bit1 receive, bit2 stopped. A set write ORs them in and a clear write removes them. `irq` is high exactly when some event is set with its enable set.
- R10: A count write above `MAX_WORDS` stores `MAX_WORDS` and a write of 0 stores 1; both set `cntErr`. A legal count write clears `cntErr`. A clamped count gives buffers of exactly that many words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| wordTick | input | 1 | Framing engine word-slot pulse |
| rxWord | input | DATA_W | Captured word from the framing engine |
| txWord | output | DATA_W | Next word for the framing engine |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid in the request cycle |
| evtTxPtr | output | 1 | Transmit pointer-updated event |
| evtRxPtr | output | 1 | Receive pointer-updated event |
| evtStopped | output | 1 | Stopped event |
| irq | output | 1 | Interrupt request |
| cntErr | output | 1 | Word-count clamp error flag |

## Verification
A corrupted word index or base register shows up on `memAddr` at the very next write or read slot, which is at most three cycles after a tick. A wrong count or a wrong last-word decision moves the pointer-updated event to the wrong tick and makes the address jump early or late, so the error becomes visible within one buffer. A wrong slot sequencer or a stale direction-active flag shows up as a missing or extra request in a specific cycle. The bench therefore compares every output against its behavioural model on every clock.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] IDX_START   = 4'd0;
  localparam logic [REG_AW-1:0] IDX_STOP    = 4'd1;
  localparam logic [REG_AW-1:0] IDX_ENABLE  = 4'd2;
  localparam logic [REG_AW-1:0] IDX_TXPTR   = 4'd3;
  localparam logic [REG_AW-1:0] IDX_RXPTR   = 4'd4;
  localparam logic [REG_AW-1:0] IDX_WORDCNT = 4'd5;
  localparam logic [REG_AW-1:0] IDX_EVT_TX  = 4'd6;
  localparam logic [REG_AW-1:0] IDX_EVT_RX  = 4'd7;
  localparam logic [REG_AW-1:0] IDX_EVT_STP = 4'd8;
  localparam logic [REG_AW-1:0] IDX_IE_SET  = 4'd9;
  localparam logic [REG_AW-1:0] IDX_IE_CLR  = 4'd10;

  localparam int NUM_EVT = 3;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WR   = 2'd1,
    SLOT_RD   = 2'd2
  } slot_e;

  typedef struct packed {
    logic latchBases;
    logic advanceIdx;
    logic captureRx;
    logic captureTx;
    logic issueWr;
    logic issueRd;
  } dp_strobe_t;

endpackage

// File: rtl/dma_ptr_datapath.sv
module dma_ptr_datapath
  import dma_ptr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  dp_strobe_t        strobe,
  input  logic [DATA_W-1:0] rxWord,
  input  logic [DATA_W-1:0] memRdata,
  output logic              lastWord,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] txWord,
  output logic              cntErr
);

  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WORDS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] txPtrReg, rxPtrReg;
  logic [ADDR_W-1:0] txBase, rxBase;
  logic [CNT_W-1:0]  cntReg, curCnt, wordIdx;
  logic [DATA_W-1:0] rxHold;
  logic [ADDR_W-1:0] wordOffset;

  logic wrTxPtr, wrRxPtr, wrCnt;
  assign wrTxPtr = regWe && (regAddr == IDX_TXPTR);
  assign wrRxPtr = regWe && (regAddr == IDX_RXPTR);
  assign wrCnt   = regWe && (regAddr == IDX_WORDCNT);

  // Pointer registers keep only word-aligned addresses.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPtrReg <= '0;
      rxPtrReg <= '0;
    end else begin
      if (wrTxPtr) txPtrReg <= {regWdata[ADDR_W-1:2], 2'b00};
      if (wrRxPtr) rxPtrReg <= {regWdata[ADDR_W-1:2], 2'b00};
    end
  end

  // Shared word count with clamping to the legal range.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= CNT_ONE;
      cntErr <= 1'b0;
    end else if (wrCnt) begin
      if (regWdata == 32'd0) begin
        cntReg <= CNT_ONE;
        cntErr <= 1'b1;
      end else if (regWdata > 32'(MAX_WORDS)) begin
        cntReg <= CNT_MAX;
        cntErr <= 1'b1;
      end else begin
        cntReg <= regWdata[CNT_W-1:0];
        cntErr <= 1'b0;
      end
    end
  end

  // Working bases, active count and word index.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBase  <= '0;
      rxBase  <= '0;
      curCnt  <= CNT_ONE;
      wordIdx <= '0;
    end else if (strobe.latchBases) begin
      txBase  <= txPtrReg;
      rxBase  <= rxPtrReg;
      curCnt  <= cntReg;
      wordIdx <= '0;
    end else if (strobe.advanceIdx) begin
      wordIdx <= wordIdx + CNT_ONE;
    end
  end

  assign lastWord = (wordIdx == (curCnt - CNT_ONE));

  // Data capture on both sides of the memory.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold <= '0;
      txWord <= '0;
    end else begin
      if (strobe.captureRx) rxHold <= rxWord;
      if (strobe.captureTx) txWord <= memRdata;
    end
  end

  assign wordOffset = ADDR_W'(wordIdx) << 2;
  assign memReq     = strobe.issueWr || strobe.issueRd;
  assign memWe      = strobe.issueWr;
  assign memAddr    = strobe.issueWr ? (rxBase + wordOffset) : (txBase + wordOffset);
  assign memWdata   = rxHold;

endmodule

// File: rtl/dma_ptr_ctrl.sv
module dma_ptr_ctrl
  import dma_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              wordTick,
  input  logic              lastWord,
  output dp_strobe_t        strobe,
  output logic              evtTxPtr,
  output logic              evtRxPtr,
  output logic              evtStopped,
  output logic              irq
);

  logic              running, txOn, rxOn;
  slot_e             slot;
  logic [1:0]        enReg;
  logic [NUM_EVT-1:0] evtBits, evtSet, evtClr, intEn;

  logic wrStart, wrStop, wrEnable, startTake, rdDone, wrapNow, txOff, rxOff;

  assign wrStart   = regWe && (regAddr == IDX_START);
  assign wrStop    = regWe && (regAddr == IDX_STOP);
  assign wrEnable  = regWe && (regAddr == IDX_ENABLE);
  assign startTake = wrStart && !running && !wrStop;
  assign rdDone    = running && !wrStop && (slot == SLOT_RD);
  assign wrapNow   = rdDone && lastWord;
  assign txOff     = running && !wrStop && wrEnable && !regWdata[0] && txOn;
  assign rxOff     = running && !wrStop && wrEnable && !regWdata[1] && rxOn;

  always_comb begin
    strobe            = '0;
    strobe.latchBases = startTake || wrapNow;
    strobe.advanceIdx = rdDone && !lastWord;
    strobe.captureRx  = running && !wrStop && (slot == SLOT_IDLE) && wordTick;
    strobe.captureTx  = rdDone && txOn;
    strobe.issueWr    = (slot == SLOT_WR) && rxOn;
    strobe.issueRd    = (slot == SLOT_RD) && txOn;
  end

  // Run state and per-direction activity.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      txOn    <= 1'b0;
      rxOn    <= 1'b0;
      slot    <= SLOT_IDLE;
    end else if (wrStop) begin
      running <= 1'b0;
      txOn    <= 1'b0;
      rxOn    <= 1'b0;
      slot    <= SLOT_IDLE;
    end else if (startTake) begin
      running <= 1'b1;
      txOn    <= enReg[0];
      rxOn    <= enReg[1];
      slot    <= SLOT_IDLE;
    end else if (running) begin
      if (txOff) txOn <= 1'b0;
      if (rxOff) rxOn <= 1'b0;
      unique case (slot)
        SLOT_IDLE: if (wordTick) slot <= SLOT_WR;
        SLOT_WR:   slot <= SLOT_RD;
        SLOT_RD:   slot <= SLOT_IDLE;
        default:   slot <= SLOT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) enReg <= 2'b00;
    else if (wrEnable) enReg <= regWdata[1:0];
  end

  // Event sources: transmit, receive, stopped.
  assign evtSet[0] = (startTake && enReg[0]) || (wrapNow && txOn) || txOff;
  assign evtSet[1] = (startTake && enReg[1]) || (wrapNow && rxOn) || rxOff;
  assign evtSet[2] = wrStop;

  localparam logic [REG_AW-1:0] EVT_IDX [NUM_EVT] = '{IDX_EVT_TX, IDX_EVT_RX, IDX_EVT_STP};

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    assign evtClr[e] = regWe && (regAddr == EVT_IDX[e]) && (regWdata == 32'd0);
    always_ff @(posedge clk) begin
      if (!rstN) evtBits[e] <= 1'b0;
      else if (evtSet[e]) evtBits[e] <= 1'b1;
      else if (evtClr[e]) evtBits[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) intEn <= '0;
    else if (regWe && (regAddr == IDX_IE_SET)) intEn <= intEn | regWdata[NUM_EVT-1:0];
    else if (regWe && (regAddr == IDX_IE_CLR)) intEn <= intEn & ~regWdata[NUM_EVT-1:0];
  end

  assign evtTxPtr   = evtBits[0];
  assign evtRxPtr   = evtBits[1];
  assign evtStopped = evtBits[2];
  assign irq        = |(evtBits & intEn);

endmodule

// File: rtl/audio_dma_ptr.sv
module audio_dma_ptr
  import dma_ptr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              wordTick,
  input  logic [DATA_W-1:0] rxWord,
  output logic [DATA_W-1:0] txWord,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              evtTxPtr,
  output logic              evtRxPtr,
  output logic              evtStopped,
  output logic              irq,
  output logic              cntErr
);

  dp_strobe_t strobe;
  logic       lastWord;

  dma_ptr_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .wordTick   (wordTick),
    .lastWord   (lastWord),
    .strobe     (strobe),
    .evtTxPtr   (evtTxPtr),
    .evtRxPtr   (evtRxPtr),
    .evtStopped (evtStopped),
    .irq        (irq)
  );

  dma_ptr_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_WORDS (MAX_WORDS)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe),
    .rxWord   (rxWord),
    .memRdata (memRdata),
    .lastWord (lastWord),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .txWord   (txWord),
    .cntErr   (cntErr)
  );

endmodule

// File: rtl/audio_dma_ptr_chk.sv
module audio_dma_ptr_chk #(
  parameter int MAX_WORDS = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [3:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        memReq,
  input logic        memWe,
  input logic [1:0]  addrLow,
  input logic        evtTxPtr,
  input logic        evtRxPtr,
  input logic        evtStopped,
  input logic        irq,
  input logic        cntErr
);

  // R2: every request is word aligned
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (addrLow == 2'b00));

  // R4: a write slot is always followed by a non-write cycle
  assert_wr_then_rd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> !memWe);

  // R7: stop raises the stopped event
  assert_stop_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 4'd1) |=> evtStopped);

  // R7: no traffic right after stop
  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 4'd1) |=> !memReq);

  // R9: no interrupt without a pending event
  assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(evtTxPtr || evtRxPtr || evtStopped) |-> !irq);

  // R10: out-of-range count write flags an error
  assert_clamp_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 4'd5 && (regWdata == 32'd0 || regWdata > 32'(MAX_WORDS))) |=> cntErr);

endmodule

bind audio_dma_ptr audio_dma_ptr_chk #(.MAX_WORDS(MAX_WORDS)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .memReq     (memReq),
  .memWe      (memWe),
  .addrLow    (memAddr[1:0]),
  .evtTxPtr   (evtTxPtr),
  .evtRxPtr   (evtRxPtr),
  .evtStopped (evtStopped),
  .irq        (irq),
  .cntErr     (cntErr)
);

// File: tb/test_audio_dma_ptr.sv
module test_audio_dma_ptr;

  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        wordTick = 1'b0;
  logic [31:0] rxWord = '0;
  logic [31:0] txWord, memAddr, memWdata, memRdata;
  logic        memReq, memWe, evtTxPtr, evtRxPtr, evtStopped, irq, cntErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return a * 32'd3 + 32'h1000;
  endfunction

  assign memRdata = memFn(memAddr);

  audio_dma_ptr i_audio_dma_ptr (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .wordTick(wordTick), .rxWord(rxWord), .txWord(txWord),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .evtTxPtr(evtTxPtr), .evtRxPtr(evtRxPtr),
    .evtStopped(evtStopped), .irq(irq), .cntErr(cntErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mRun, mTxOn, mRxOn;
  int          mSlot, mIdx, mCur, mCnt;
  bit          mErr;
  logic [31:0] mTxPtr, mRxPtr, mTxBase, mRxBase, mRxLatch, mTxWord;
  logic [1:0]  mEn;
  logic [2:0]  mEvt, mIe;

  always @(posedge clk) begin
    logic [2:0] setB, clrB;
    bit stopW, startW;
    if (!rstN) begin
      mRun = 0; mTxOn = 0; mRxOn = 0; mSlot = 0; mIdx = 0; mCur = 1; mCnt = 1; mErr = 0;
      mTxPtr = 0; mRxPtr = 0; mTxBase = 0; mRxBase = 0; mRxLatch = 0; mTxWord = 0;
      mEn = 0; mEvt = 0; mIe = 0;
    end else begin
      setB = 0; clrB = 0;
      stopW  = regWe && regAddr == 4'd1;
      startW = regWe && regAddr == 4'd0 && !mRun && !stopW;
      for (int e = 0; e < 3; e++)
        if (regWe && regAddr == 4'(6 + e) && regWdata == 0) clrB[e] = 1'b1;
      if (stopW) begin
        mRun = 0; mTxOn = 0; mRxOn = 0; mSlot = 0; setB[2] = 1'b1;
      end else if (startW) begin
        mRun = 1; mTxOn = mEn[0]; mRxOn = mEn[1]; mSlot = 0;
        mTxBase = mTxPtr; mRxBase = mRxPtr; mCur = mCnt; mIdx = 0;
        setB[0] = mEn[0]; setB[1] = mEn[1];
      end else if (mRun) begin
        bit offT, offR;
        offT = regWe && regAddr == 4'd2 && !regWdata[0] && mTxOn;
        offR = regWe && regAddr == 4'd2 && !regWdata[1] && mRxOn;
        if (mSlot == 0) begin
          if (wordTick) begin mSlot = 1; mRxLatch = rxWord; end
        end else if (mSlot == 1) begin
          mSlot = 2;
        end else begin
          mSlot = 0;
          if (mTxOn) mTxWord = memFn(mTxBase + 32'(4 * mIdx));
          if (mIdx == mCur - 1) begin
            if (mTxOn) setB[0] = 1'b1;
            if (mRxOn) setB[1] = 1'b1;
            mTxBase = mTxPtr; mRxBase = mRxPtr; mCur = mCnt; mIdx = 0;
          end else mIdx++;
        end
        if (offT) begin mTxOn = 0; setB[0] = 1'b1; end
        if (offR) begin mRxOn = 0; setB[1] = 1'b1; end
      end
      if (regWe) begin
        case (regAddr)
          4'd2: mEn = regWdata[1:0];
          4'd3: mTxPtr = regWdata & ~32'd3;
          4'd4: mRxPtr = regWdata & ~32'd3;
          4'd5: begin
            if (regWdata == 0) begin mCnt = 1; mErr = 1; end
            else if (regWdata > MAXW) begin mCnt = MAXW; mErr = 1; end
            else begin mCnt = int'(regWdata); mErr = 0; end
          end
          4'd9:  mIe = mIe | regWdata[2:0];
          4'd10: mIe = mIe & ~regWdata[2:0];
          default: ;
        endcase
      end
      mEvt = (mEvt & ~clrB) | setB;
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expWr, expRd;
      expWr = (mSlot == 1) && mRxOn;
      expRd = (mSlot == 2) && mTxOn;
      chk("R4 memReq", 32'(memReq), 32'(expWr || expRd));
      chk("R4 memWe", 32'(memWe), 32'(expWr));
      if (expWr) begin
        chk("R2 rx address", memAddr, mRxBase + 32'(4 * mIdx));
        chk("R4 write data", memWdata, mRxLatch);
      end
      if (expRd) chk("R2 tx address", memAddr, mTxBase + 32'(4 * mIdx));
      chk("R4 txWord", txWord, mTxWord);
      chk("R5 evtTxPtr", 32'(evtTxPtr), 32'(mEvt[0]));
      chk("R5 evtRxPtr", 32'(evtRxPtr), 32'(mEvt[1]));
      chk("R7 evtStopped", 32'(evtStopped), 32'(mEvt[2]));
      chk("R9 irq", 32'(irq), 32'(|(mEvt & mIe)));
      chk("R10 cntErr", 32'(cntErr), 32'(mErr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic tick(input logic [31:0] d);
    @(negedge clk);
    wordTick = 1'b1; rxWord = d;
    @(negedge clk);
    wordTick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 events", {29'd0, evtStopped, evtRxPtr, evtTxPtr}, 32'd0);
    chk("R1 irq/err/req", {29'd0, irq, cntErr, memReq}, 32'd0);
    chk("R1 txWord", txWord, 32'd0);

    wr(4'd9, 32'd7);
    wr(4'd3, 32'h100);
    wr(4'd4, 32'h201);
    wr(4'd5, 32'd3);
    wr(4'd2, 32'd3);
    wr(4'd0, 32'd0);
    chk("R3 start tx event", 32'(evtTxPtr), 32'd1);
    chk("R3 start rx event", 32'(evtRxPtr), 32'd1);
    chk("R9 irq on event", 32'(irq), 32'd1);

    // R4 first word, timed by hand
    @(negedge clk); wordTick = 1'b1; rxWord = 32'hCAFE0001;
    @(negedge clk); wordTick = 1'b0;
    chk("R4 write slot", {30'd0, memReq, memWe}, 32'd3);
    chk("R2 aligned rx base", memAddr, 32'h200);
    chk("R4 rx data", memWdata, 32'hCAFE0001);
    @(negedge clk);
    chk("R4 read slot", {30'd0, memReq, memWe}, 32'd2);
    chk("R2 tx base", memAddr, 32'h100);
    @(negedge clk);
    chk("R4 txWord value", txWord, memFn(32'h100));

    wr(4'd6, 32'd0);
    wr(4'd7, 32'd0);
    chk("R8 cleared by zero", {30'd0, evtRxPtr, evtTxPtr}, 32'd0);
    tick(32'hCAFE0002);
    wr(4'd3, 32'h400);
    tick(32'hCAFE0003);
    chk("R5 wrap events", {30'd0, evtRxPtr, evtTxPtr}, 32'd3);
    wr(4'd6, 32'd5);
    chk("R8 nonzero ignored", 32'(evtTxPtr), 32'd1);

    // R5 continues at reloaded tx base and reused rx base
    @(negedge clk); wordTick = 1'b1; rxWord = 32'hCAFE0004;
    @(negedge clk); wordTick = 1'b0;
    chk("R5 reused rx ptr", memAddr, 32'h200);
    @(negedge clk);
    chk("R5 new tx ptr", memAddr, 32'h400);
    @(negedge clk);

    wr(4'd6, 32'd0);
    wr(4'd7, 32'd0);
    wr(4'd0, 32'd0);
    chk("R3 start while running", {30'd0, evtRxPtr, evtTxPtr}, 32'd0);
    @(negedge clk); wordTick = 1'b1; rxWord = 32'hCAFE0005;
    @(negedge clk); wordTick = 1'b0;
    @(negedge clk);
    chk("R3 index kept", memAddr, 32'h404);
    @(negedge clk);

    wr(4'd2, 32'd2);
    chk("R6 disable event", 32'(evtTxPtr), 32'd1);
    @(negedge clk); wordTick = 1'b1; rxWord = 32'hCAFE0006;
    @(negedge clk); wordTick = 1'b0;
    chk("R6 rx still writes", 32'(memWe), 32'd1);
    @(negedge clk);
    chk("R6 tx silent", 32'(memReq), 32'd0);
    @(negedge clk);
    wr(4'd2, 32'd3);
    tick(32'hCAFE0007);

    wr(4'd1, 32'd0);
    chk("R7 stopped event", 32'(evtStopped), 32'd1);
    @(negedge clk); wordTick = 1'b1;
    @(negedge clk); wordTick = 1'b0;
    chk("R7 no traffic", 32'(memReq), 32'd0);
    @(negedge clk);
    chk("R7 no traffic read", 32'(memReq), 32'd0);
    wr(4'd10, 32'd7);
    chk("R9 disabled irq", 32'(irq), 32'd0);

    wr(4'd5, 32'd300);
    chk("R10 clamp high", 32'(cntErr), 32'd1);
    wr(4'd5, 32'd4);
    chk("R10 legal clears", 32'(cntErr), 32'd0);
    wr(4'd5, 32'd0);
    chk("R10 zero flagged", 32'(cntErr), 32'd1);
    wr(4'd5, 32'd1000);
    for (int e = 6; e < 9; e++) wr(4'(e), 32'd0);
    wr(4'd0, 32'd0);
    wr(4'd7, 32'd0);
    seen = 0;
    for (int k = 1; k <= MAXW + 2; k++) begin
      tick(k);
      if (evtRxPtr && seen == 0) seen = k;
    end
    chk("R10 clamped buffer length", 32'(seen), 32'(MAXW));

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule